// File: doc/BRIEF.md
# Serial EEPROM Page Write Buffer and Commit Sequencer

This block sits between the bus protocol engine of a small serial EEPROM and its storage array. A write transfer first loads a word address. The data bytes that follow are gathered into an eight-slot page latch. Each byte goes to the slot given by the current in-page offset, and that offset wraps inside the aligned eight-byte page. If more than eight bytes arrive, the later ones replace the earlier ones.

When the protocol engine reports a Stop, the block scans the latch and writes the received slots into the array, one per clock. It then keeps `busy` high for a write-cycle time counted in clocks. The protocol engine uses `busy` to withhold acknowledges. An abort pulse, which marks a repeated Start, throws the latch away without a commit.

The write-protect level is sampled at the Stop. With protection on, the upper half of the array (word addresses 80h to FFh) is silently left alone and `busy` stays low.

Top module: `eeprom_page_writer`

## Requirements
- R1: After a synchronous reset, `busy` is 0 and `mem_we` is 0 until a Stop commits received data.
- R2: The k-th data byte (k counting from 0) after an address load of `a` is written to address `{a[7:3], (a[2:0]+k) mod 8}`. Bits 7..3 of the address never change within one commit.
- R3: When more than eight bytes arrive, each in-page slot keeps the value of the last byte that landed in it, and at most eight array writes occur.
- R4: A commit starts only on `stop_pls` when at least one byte is latched. An `abort_pls` or a new address load empties the latch. A Stop with an empty latch produces no write and no `busy`.
- R5: Only slots that received a byte are written; every other array location keeps its contents.
- R6: `wp_lvl` is sampled in the cycle of `stop_pls`. If it is 1 and address bit 7 is 1, nothing is written and `busy` never rises. Changing `wp_lvl` after that cycle has no effect on the commit.
- R7: With `wp_lvl`=1, pages in the lower half (address bit 7 = 0) are written normally. With `wp_lvl`=0, both halves are writable.
- R8: After a committing Stop, `busy` is high from the next cycle for exactly PAGE_N + WCYC_CLKS cycles. Writes occur only while `busy` is high, in ascending slot order.
- R9: While `busy` is high, `addr_ld`, `byte_stb`, `stop_pls` and `abort_pls` are ignored. No stray write or extra busy period follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_ld | input | 1 | Word address received pulse |
| addr_val | input | ADDR_W | Word address (page bits and start offset) |
| byte_stb | input | 1 | Data byte received pulse |
| byte_val | input | DATA_W | Received data byte |
| stop_pls | input | 1 | Stop condition received pulse |
| abort_pls | input | 1 | Repeated Start: discard latched bytes |
| wp_lvl | input | 1 | Write-protect level for the upper half |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Commit scan or write cycle in progress |

## Verification
The bench runs the full cross of every start offset within the page, byte counts of 0, 1, 3, 8, 9 and 13, and pages in both halves of the array, each with protection on and off. The protect level is always flipped just after the Stop. Byte counts under eight separate partial-slot commits from full ones. Counts past eight expose the wrap and the last-writer-wins rule, and the zero count shows that an empty Stop does nothing. The protected and unprotected halves, with the level flipped after the Stop, show that protection is judged only at the Stop. Two extra scenarios check that an abort discards the latch and that bus events during `busy` leave the array untouched.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SCAN = 2'd1,
        SQ_HOLD = 2'd2
    } seq_state_e;

    // Upper-half guard: blocks a page whose top address bit is set while protect is on
    function automatic logic half_guarded(input logic upper_half, input logic wp);
        return upper_half & wp;
    endfunction

    // Counter width able to hold values 0 .. lim-1
    function automatic int unsigned ctr_width(input int unsigned lim);
        return (lim < 2) ? 1 : $clog2(lim);
    endfunction

endpackage

// File: rtl/pgw_page_latch.sv
module pgw_page_latch #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int PAGE_N = 8,
    localparam int OFF_W = $clog2(PAGE_N),
    localparam int PG_W  = ADDR_W - OFF_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          accept,
    input  logic                          addr_ld,
    input  logic [ADDR_W-1:0]             addr_val,
    input  logic                          byte_stb,
    input  logic [DATA_W-1:0]             byte_val,
    input  logic                          abort_pls,
    input  logic                          clr,
    output logic [PG_W-1:0]               page_base,
    output logic [PAGE_N-1:0]             slot_vld,
    output logic [PAGE_N-1:0][DATA_W-1:0] slot_dat
);

    logic [OFF_W-1:0] off_q;
    logic             take_addr;
    logic             take_byte;
    logic             flush;

    assign take_addr = accept & addr_ld;
    assign take_byte = accept & byte_stb & ~addr_ld;
    assign flush     = clr | (accept & abort_pls) | take_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q     <= '0;
            page_base <= '0;
        end else if (take_addr) begin
            off_q     <= addr_val[OFF_W-1:0];
            page_base <= addr_val[ADDR_W-1:OFF_W];
        end else if (take_byte) begin
            off_q     <= off_q + 1'b1;
        end
    end

    for (genvar g = 0; g < PAGE_N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_vld[g] <= 1'b0;
                slot_dat[g] <= '0;
            end else if (flush) begin
                slot_vld[g] <= 1'b0;
            end else if (take_byte && off_q == OFF_W'(g)) begin
                slot_vld[g] <= 1'b1;
                slot_dat[g] <= byte_val;
            end
        end
    end

endmodule

// File: rtl/pgw_cycle_timer.sv
module pgw_cycle_timer #(
    parameter int unsigned WCYC_CLKS = 250000,
    localparam int unsigned CW = pgw_pkg::ctr_width(WCYC_CLKS)
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(WCYC_CLKS - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pgw_commit_seq.sv
module pgw_commit_seq #(
    parameter int PAGE_N = 8,
    parameter int PG_W   = 5,
    localparam int OFF_W = $clog2(PAGE_N)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   stop_pls,
    input  logic                   wp_lvl,
    input  logic [PAGE_N-1:0]      slot_vld,
    input  logic [PG_W-1:0]        page_in,
    input  logic                   tmr_expired,
    output pgw_pkg::seq_state_e    state,
    output logic [OFF_W-1:0]       idx,
    output logic [PG_W-1:0]        page_q,
    output logic                   wp_q,
    output logic                   wr_en,
    output logic                   latch_clr,
    output logic                   tmr_load
);
    import pgw_pkg::*;

    logic go;
    logic last;

    assign go   = stop_pls & (|slot_vld) & ~half_guarded(page_in[PG_W-1], wp_lvl);
    assign last = (idx == OFF_W'(PAGE_N - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            idx    <= '0;
            page_q <= '0;
            wp_q   <= 1'b0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (stop_pls) begin
                        wp_q   <= wp_lvl;
                        page_q <= page_in;
                    end
                    if (go) begin
                        state <= SQ_SCAN;
                        idx   <= '0;
                    end
                end
                SQ_SCAN: begin
                    idx <= idx + 1'b1;
                    if (last) state <= SQ_HOLD;
                end
                SQ_HOLD: begin
                    if (tmr_expired) state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        wr_en     = (state == SQ_SCAN) & slot_vld[idx];
        tmr_load  = (state == SQ_SCAN) & last;
        latch_clr = ((state == SQ_IDLE) & stop_pls & ~go) | tmr_load;
    end

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 8,
    parameter int          PAGE_N    = 8,
    parameter int unsigned WCYC_CLKS = 250000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_ld,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_val,
    input  logic              stop_pls,
    input  logic              abort_pls,
    input  logic              wp_lvl,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy
);
    import pgw_pkg::*;

    localparam int OFF_W = $clog2(PAGE_N);
    localparam int PG_W  = ADDR_W - OFF_W;

    logic [PG_W-1:0]               page_base;
    logic [PAGE_N-1:0]             slot_vld;
    logic [PAGE_N-1:0][DATA_W-1:0] slot_dat;
    seq_state_e                    state;
    logic [OFF_W-1:0]              idx;
    logic [PG_W-1:0]               page_q;
    logic                          wp_q;
    logic                          latch_clr;
    logic                          tmr_load;
    logic                          tmr_expired;

    pgw_page_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PAGE_N (PAGE_N)
    ) u_latch (
        .clk       (clk),
        .rst       (rst),
        .accept    (~busy),
        .addr_ld   (addr_ld),
        .addr_val  (addr_val),
        .byte_stb  (byte_stb),
        .byte_val  (byte_val),
        .abort_pls (abort_pls),
        .clr       (latch_clr),
        .page_base (page_base),
        .slot_vld  (slot_vld),
        .slot_dat  (slot_dat)
    );

    pgw_commit_seq #(
        .PAGE_N (PAGE_N),
        .PG_W   (PG_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .stop_pls    (stop_pls & ~busy),
        .wp_lvl      (wp_lvl),
        .slot_vld    (slot_vld),
        .page_in     (page_base),
        .tmr_expired (tmr_expired),
        .state       (state),
        .idx         (idx),
        .page_q      (page_q),
        .wp_q        (wp_q),
        .wr_en       (mem_we),
        .latch_clr   (latch_clr),
        .tmr_load    (tmr_load)
    );

    pgw_cycle_timer #(
        .WCYC_CLKS (WCYC_CLKS)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    assign busy      = (state != SQ_IDLE);
    assign mem_addr  = {page_q, idx};
    assign mem_wdata = slot_dat[idx];

endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
    parameter int ADDR_W = 8,
    parameter int OFF_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              stop_pls,
    input logic              any_vld,
    input logic              wp_q
);

    AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy); // R8

    AST_WE_NOT_GUARDED: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !(wp_q && mem_addr[ADDR_W-1])); // R6

    AST_PAGE_STEADY: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W]))); // R2

    AST_SLOT_ASCEND: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr[OFF_W-1:0] > $past(mem_addr[OFF_W-1:0]))); // R8

    AST_EMPTY_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        (stop_pls && !busy && !any_vld) |=> !busy); // R4

    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_pls)); // R4

endmodule

bind eeprom_page_writer pgw_checker #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
) u_pgw_checker (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .stop_pls (stop_pls),
    .any_vld  (|slot_vld),
    .wp_q     (wp_q)
);

// File: tb/tb_eeprom_page_writer.sv
`timescale 1ns/1ps
module tb_eeprom_page_writer;

    localparam int WCYC = 12;
    localparam int PGN  = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr_ld = 1'b0;
    logic [7:0] addr_val = '0;
    logic       byte_stb = 1'b0;
    logic [7:0] byte_val = '0;
    logic       stop_pls = 1'b0;
    logic       abort_pls = 1'b0;
    logic       wp_lvl = 1'b0;
    logic       mem_we;
    logic [7:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       busy;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    logic [7:0] arr  [256];
    logic [7:0] expm [256];

    always #10 clk = ~clk;

    eeprom_page_writer #(
        .ADDR_W (8), .DATA_W (8), .PAGE_N (PGN), .WCYC_CLKS (WCYC)
    ) dut (
        .clk (clk), .rst (rst), .addr_ld (addr_ld), .addr_val (addr_val),
        .byte_stb (byte_stb), .byte_val (byte_val), .stop_pls (stop_pls),
        .abort_pls (abort_pls), .wp_lvl (wp_lvl), .mem_we (mem_we),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata), .busy (busy)
    );

    // Bench-side array fed by the write port
    always @(negedge clk) begin
        if (mem_we === 1'b1) begin
            arr[mem_addr] = mem_wdata;
            wr_cnt++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dval(input int sd, input int k);
        return 8'(sd * 29 + k * 53 + 7);
    endfunction

    function automatic int mismatches();
        int m = 0;
        for (int i = 0; i < 256; i++) if (arr[i] !== expm[i]) m++;
        return m;
    endfunction

    task automatic send_addr(input logic [7:0] a);
        addr_ld = 1'b1; addr_val = a; @(negedge clk); addr_ld = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        byte_stb = 1'b1; byte_val = d; @(negedge clk); byte_stb = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy === 1'b1 && n < 500) begin n++; @(negedge clk); end
        @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] a, input int nb, input logic wp_s,
                        input logic wp_a, input int sd);
        logic guard;
        int   exp_wr, exp_busy, n;
        guard  = wp_s & a[7];
        exp_wr = (nb == 0 || guard) ? 0 : ((nb > PGN) ? PGN : nb);
        exp_busy = (exp_wr > 0) ? PGN + WCYC : 0;
        for (int k = 0; k < nb; k++)
            if (!guard) expm[{a[7:3], 3'(a[2:0] + k)}] = dval(sd, k);
        wr_cnt = 0;
        wp_lvl = wp_s;
        send_addr(a);
        for (int k = 0; k < nb; k++) send_byte(dval(sd, k));
        stop_pls = 1'b1; @(negedge clk); stop_pls = 1'b0;
        wp_lvl = wp_a;
        count_busy(n);
        check(n == exp_busy, "R8 R6 R4 busy length", n, exp_busy);
        check(wr_cnt == exp_wr, "R3 R5 R6 write count", wr_cnt, exp_wr);
        check(mismatches() == 0, "R2 R3 R5 R7 array contents", mismatches(), 0);
    endtask

    initial begin
        int n, sd;
        logic [7:0] pages [4];
        int counts [6];
        pages  = '{8'h00, 8'h48, 8'h80, 8'hF8};
        counts = '{0, 1, 3, 8, 9, 13};
        for (int i = 0; i < 256; i++) begin
            arr[i]  = 8'(i * 7 + 3);
            expm[i] = 8'(i * 7 + 3);
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
            check(mem_we === 1'b0, "R1 mem_we after reset", int'(mem_we), 0);
            @(negedge clk);
        end

        // Sweep: protect level, page, start offset, byte count
        sd = 1;
        for (int w = 0; w < 2; w++)
            for (int p = 0; p < 4; p++)
                for (int o = 0; o < 8; o++)
                    for (int c = 0; c < 6; c++) begin
                        xfer(pages[p] | 8'(o), counts[c], w[0], ~w[0], sd);
                        sd++;
                    end

        // R4: abort discards latched bytes
        wr_cnt = 0;
        send_addr(8'h30);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
        abort_pls = 1'b1; @(negedge clk); abort_pls = 1'b0;
        stop_pls = 1'b1; @(negedge clk); stop_pls = 1'b0;
        count_busy(n);
        check(n == 0, "R4 busy after abort", n, 0);
        check(wr_cnt == 0, "R4 writes after abort", wr_cnt, 0);
        check(mismatches() == 0, "R4 array after abort", mismatches(), 0);

        // R9: bus events while busy are ignored
        wr_cnt = 0;
        wp_lvl = 1'b0;
        send_addr(8'h12);
        send_byte(8'h9C); send_byte(8'h9D);
        expm[8'h12] = 8'h9C; expm[8'h13] = 8'h9D;
        stop_pls = 1'b1; @(negedge clk); stop_pls = 1'b0;
        send_addr(8'h20);
        send_byte(8'h55);
        stop_pls = 1'b1; @(negedge clk); stop_pls = 1'b0;
        abort_pls = 1'b1; @(negedge clk); abort_pls = 1'b0;
        count_busy(n);
        check(n == PGN + WCYC - 4, "R9 R8 busy remaining", n, PGN + WCYC - 4);
        repeat (3) @(negedge clk);
        check(busy === 1'b0, "R9 no second busy period", int'(busy), 0);
        check(wr_cnt == 2, "R9 write count", wr_cnt, 2);
        check(mismatches() == 0, "R9 array after ignored events", mismatches(), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule